// File: doc/BRIEF.md
# Oversampled Polyphase Synthesis Windower

This block is the output stage of an oversampled synthesis filter bank. An inverse transform upstream delivers one time-domain frame of 128 samples per frame period, one sample per accepted clock. The block rotates the frame circularly by an amount tied to the frame count. It repeats the rotated frame periodically out to the 320-tap prototype length and weights it with a fixed window. The weighted result is added into a 320-entry overlap buffer. The 32 oldest buffer entries then leave the block as output samples, one per clock.

Thirty-two output samples per 128-point frame means a hop of a quarter frame. At a 20 MS/s output rate the frame rate is 625 kHz. Because the hop is not the frame size, the start of each frame has to be realigned by a rotation that cycles through four values. The intrinsic delay of the prototype is (L-1)/2 = 159.5 output samples, close to 8 us at 20 MS/s. The upstream source sees `frame_ready` drop while a burst is being emitted, and it must hold the next frame until `frame_ready` returns.

Top module: `osw_windower`

## Requirements
- R1: After reset, `frame_ready` is 1, `smp_valid` is 0 and every overlap-buffer entry is zero, so the first burst after reset depends only on the first frame.
- R2: A sample is accepted on each clock with `frame_valid` and `frame_ready` high. On the clock after the 128th acceptance, `frame_ready` goes to 0 and `smp_valid` goes to 1 for exactly 32 consecutive cycles. `frame_ready` returns to 1 on the cycle after the last valid output.
- R3: `frame_valid` and `frame_data` presented while `frame_ready` is 0 are ignored and leave the output stream unchanged.
- R4: Frame n after reset (n counted from 0) has rotation r = (32*n) mod 128. The windowed sample at position i (0..319) is h[i]*x[(i+r) mod 128], where x[j] is the j-th sample accepted in that frame.
- R5: The window is h[i] = 800*min(i+1, 320-i), held as 18-bit signed values with 2^17 standing for unity.
- R6: Each product is rounded to a 17-bit signed term as floor((x*h + 2^16) / 2^17). A half rounds toward plus infinity: x = 2048 against h[0] gives 13, and x = -2048 gives -12.
- R7: Each windowed frame is added into a 320-entry buffer. Entries 0..31 are then emitted in ascending order, the buffer moves toward entry 0 by 32 places, and zeros fill entries 288..319.
- R8: Each emitted sample is its buffer entry clamped to the signed 16-bit range [-32768, 32767].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | Upstream sample on `frame_data` is valid |
| frame_data | input | 16 | Signed time-domain sample of the current frame |
| frame_ready | output | 1 | Block accepts frame samples |
| smp_valid | output | 1 | `smp_data` holds an output sample |
| smp_data | output | 16 | Signed, saturated output sample |

## Verification
The bench builds the block with its default parameters: a 128-point frame, a 32-sample hop and a 320-tap prototype. With these values all four rotation phases are reached, together with the three-way fold of a frame across the prototype, the second fold stopping short at position 319, and ten-frame overlap depth. That depth is enough for full-scale constant frames to drive the sum past the 16-bit range and exercise both clamps. Single-sample impulses at chosen positions are used to pin down the exact half-unit rounding and the rotation step on their own. Ramps, alternating signs and full-scale frames, sent back to back with junk driven during each output burst, are then compared against an overlap-add model written from the requirements.

// File: rtl/osw_pkg.sv
// Shared definitions for the synthesis windower.
// Assumes tap indices are non-negative and less than the tap count.
package osw_pkg;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_EMIT = 1'b1
    } osw_phase_e;

    // Triangular prototype: distance to the nearer end, times a step.
    function automatic int osw_coef(int tap, int taps, int step);
        int d;
        d = (tap + 1 < taps - tap) ? tap + 1 : taps - tap;
        return d * step;
    endfunction

endpackage

// File: rtl/osw_coef_rom.sv
// Constant window table with one read port.
// Assumes: entries computed at elaboration; indices >= TAPS read as zero.
module osw_coef_rom #(
    parameter int TAPS   = 320,
    parameter int COEF_W = 18,
    parameter int STEP   = 800,
    parameter int IW     = 9
) (
    input  logic [IW-1:0]            idx,
    output logic signed [COEF_W-1:0] coef
);
    import osw_pkg::*;

    logic signed [COEF_W-1:0] tbl [TAPS];

    // Fill the table with elaboration-time constants.
    for (genvar g = 0; g < TAPS; g++) begin : g_tbl
        assign tbl[g] = COEF_W'(osw_coef(g, TAPS, STEP));
    end

    // Guarded lookup.
    always_comb begin
        coef = '0;
        if (idx < IW'(TAPS)) coef = tbl[idx];
    end
endmodule

// File: rtl/osw_tap_lane.sv
// One fold of the periodic extension: maps the incoming frame sample to
// the buffer position it lands on in fold LANE and forms the rounded product.
// Assumes K is a power of two so that the rotation wraps in KW bits.
module osw_tap_lane #(
    parameter int K      = 128,
    parameter int L      = 320,
    parameter int LANE   = 0,
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int STEP   = 800,
    parameter int IW     = 9,
    localparam int KW    = $clog2(K),
    localparam int PW    = DATA_W + COEF_W
) (
    input  logic [KW-1:0]             pos,
    input  logic [KW-1:0]             rot,
    input  logic signed [DATA_W-1:0]  sample,
    output logic                      hit,
    output logic [IW-1:0]             idx,
    output logic signed [DATA_W:0]    term
);
    logic [KW-1:0]            base;
    logic signed [COEF_W-1:0] coef;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     rnd;

    // Position of this sample within the first fold, then within this fold.
    always_comb begin
        base = pos - rot;
        idx  = IW'(base) + IW'(LANE * K);
        hit  = idx < IW'(L);
    end

    osw_coef_rom #(.TAPS(L), .COEF_W(COEF_W), .STEP(STEP), .IW(IW)) u_rom (
        .idx  (idx),
        .coef (coef)
    );

    // Multiply, add half an output LSB, drop the fraction bits.
    always_comb begin
        prod = PW'(sample) * PW'(coef);
        rnd  = prod + (PW'(1) <<< (COEF_W - 2));
        term = rnd[COEF_W-1 +: DATA_W+1];
    end
endmodule

// File: rtl/osw_frame_ctrl.sv
// Sequencer: counts frame samples in, then output samples out, and
// advances the rotation by the hop after every burst.
// Assumes K and M are powers of two and M <= K.
module osw_frame_ctrl #(
    parameter int K  = 128,
    parameter int M  = 32,
    localparam int KW = $clog2(K),
    localparam int MW = $clog2(M)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    output logic          frame_ready,
    output logic          emit,
    output logic          accept,
    output logic [KW-1:0] pos,
    output logic [KW-1:0] rot
);
    import osw_pkg::*;

    osw_phase_e    phase_q;
    logic [KW-1:0] pos_q;
    logic [MW-1:0] ocnt_q;
    logic [KW-1:0] rot_q;

    // Handshake outputs follow the registered phase.
    always_comb begin
        frame_ready = (phase_q == PH_LOAD);
        emit        = (phase_q == PH_EMIT);
        accept      = frame_valid && frame_ready;
        pos         = pos_q;
        rot         = rot_q;
    end

    // Phase, sample counters and rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOAD;
            pos_q   <= '0;
            ocnt_q  <= '0;
            rot_q   <= '0;
        end else if (phase_q == PH_LOAD) begin
            if (frame_valid) begin
                pos_q <= pos_q + 1'b1;
                if (pos_q == KW'(K - 1)) phase_q <= PH_EMIT;
            end
        end else begin
            ocnt_q <= ocnt_q + 1'b1;
            if (ocnt_q == MW'(M - 1)) begin
                phase_q <= PH_LOAD;
                rot_q   <= rot_q + KW'(M);
            end
        end
    end
endmodule

// File: rtl/osw_ola_buffer.sv
// Overlap-add store: adds lane terms at their positions on accept,
// and moves one place toward entry 0 per emitted sample.
// Assumes accept and shift are never high together; lane positions differ.
module osw_ola_buffer #(
    parameter int L      = 320,
    parameter int NL     = 3,
    parameter int IW     = 9,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       shift,
    input  logic [NL-1:0]              hit,
    input  logic [NL-1:0][IW-1:0]      idx,
    input  logic [NL-1:0][DATA_W:0]    term,
    output logic signed [ACC_W-1:0]    head
);
    logic signed [ACC_W-1:0] acc [L];

    assign head = acc[0];

    // Accumulate folds, or advance the buffer by one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < L; p++) acc[p] <= '0;
        end else if (accept) begin
            for (int m = 0; m < NL; m++) begin
                if (hit[m]) acc[idx[m]] <= acc[idx[m]] + ACC_W'($signed(term[m]));
            end
        end else if (shift) begin
            for (int p = 0; p < L - 1; p++) acc[p] <= acc[p + 1];
            acc[L-1] <= '0;
        end
    end
endmodule

// File: rtl/osw_windower.sv
// Oversampled polyphase synthesis windower (top).
// Takes K-sample frames one sample per clock and emits M samples per frame
// from an L-entry overlap-add buffer, clamped to DATA_W bits.
// Assumes K, M powers of two, M <= K, and the source honours frame_ready.
module osw_windower #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int K      = 128,
    parameter int M      = 32,
    parameter int L      = 320,
    parameter int STEP   = 800,
    localparam int KW    = $clog2(K),
    localparam int NL    = (L + K - 1) / K,
    localparam int IW    = $clog2(NL * K),
    localparam int ACC_W = DATA_W + 1 + $clog2((L + M - 1) / M)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_valid,
    input  logic signed [DATA_W-1:0] frame_data,
    output logic                     frame_ready,
    output logic                     smp_valid,
    output logic signed [DATA_W-1:0] smp_data
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(2 ** (DATA_W - 1)));

    logic                    accept;
    logic [KW-1:0]           pos;
    logic [KW-1:0]           rot;
    logic [NL-1:0]           hit;
    logic [NL-1:0][IW-1:0]   idx;
    logic [NL-1:0][DATA_W:0] term;
    logic signed [ACC_W-1:0] head;

    osw_frame_ctrl #(.K(K), .M(M)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_ready (frame_ready),
        .emit        (smp_valid),
        .accept      (accept),
        .pos         (pos),
        .rot         (rot)
    );

    // One lane per fold of the periodic extension.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic                    l_hit;
        logic [IW-1:0]           l_idx;
        logic signed [DATA_W:0]  l_term;
        osw_tap_lane #(
            .K(K), .L(L), .LANE(g), .DATA_W(DATA_W),
            .COEF_W(COEF_W), .STEP(STEP), .IW(IW)
        ) u_lane (
            .pos    (pos),
            .rot    (rot),
            .sample (frame_data),
            .hit    (l_hit),
            .idx    (l_idx),
            .term   (l_term)
        );
        assign hit[g]  = l_hit;
        assign idx[g]  = l_idx;
        assign term[g] = l_term;
    end

    osw_ola_buffer #(
        .L(L), .NL(NL), .IW(IW), .DATA_W(DATA_W), .ACC_W(ACC_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .shift  (smp_valid),
        .hit    (hit),
        .idx    (idx),
        .term   (term),
        .head   (head)
    );

    // Clamp the oldest entry to the output range.
    always_comb begin
        if (head > SAT_HI)      smp_data = DATA_W'(SAT_HI);
        else if (head < SAT_LO) smp_data = DATA_W'(SAT_LO);
        else                    smp_data = DATA_W'(head);
    end
endmodule

// File: rtl/osw_checker.sv
// Protocol checker for the windower handshake, attached by bind.
// Assumes the synchronous active-low reset is applied from time zero.
module osw_checker #(
    parameter int K = 128,
    parameter int M = 32
) (
    input logic clk,
    input logic rst_n,
    input logic frame_valid,
    input logic frame_ready,
    input logic smp_valid
);
    localparam int CW = $clog2(K) + 1;
    localparam int OW = $clog2(M) + 1;

    logic [CW-1:0] in_cnt;
    logic [OW-1:0] out_cnt;

    // Samples accepted since the last burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                          in_cnt <= '0;
        else if (smp_valid)                  in_cnt <= '0;
        else if (frame_valid && frame_ready) in_cnt <= in_cnt + 1'b1;
    end

    // Outputs issued in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !smp_valid) out_cnt <= '0;
        else                      out_cnt <= out_cnt + 1'b1;
    end

    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ready && smp_valid));

    assert_full_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> in_cnt == CW'(K));

    assert_burst_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> out_cnt < OW'(M));

    assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smp_valid) |-> out_cnt == OW'(M));

    assert_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smp_valid) |-> frame_ready);

    assert_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ready || smp_valid);
endmodule

bind osw_windower osw_checker #(.K(K), .M(M)) u_osw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_ready (frame_ready),
    .smp_valid   (smp_valid)
);

// File: tb/tb_osw_windower.sv
// Self-checking bench: directed reset, rounding and rotation tests, then a
// table of frame patterns compared against an overlap-add model.
module tb_osw_windower;
    localparam int K = 128;
    localparam int M = 32;
    localparam int L = 320;

    typedef int frame_t [K];

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_valid = 1'b0;
    logic signed [15:0] frame_data = '0;
    logic               frame_ready;
    logic               smp_valid;
    logic signed [15:0] smp_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    osw_windower dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .frame_ready (frame_ready),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data)
    );

    // Stimulus table: kind 0 impulse at ARG, 1 constant, 2 ramp AMP*(j-64), 3 alternating.
    localparam int NV = 9;
    localparam int VK [NV] = '{2, 0, 3, 1, 1, 1, 1, 2, 3};
    localparam int VA [NV] = '{40, 9000, 2500, -3000, 32767, 32767, -32768, -25, 700};
    localparam int VG [NV] = '{0, 77, 0, 0, 0, 0, 0, 0, 0};

    int    mbuf [L];
    int    mrot;
    int    exp_q [$];
    string tag_q [$];
    int    last_burst [M];
    int    bcnt = 0;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int win(int i);
        int d = (i + 1 < L - i) ? i + 1 : L - i;
        return 800 * d;
    endfunction

    function automatic int clamp16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic frame_t make_frame(int kind, int amp, int arg);
        frame_t f;
        for (int j = 0; j < K; j++) begin
            case (kind)
                0:       f[j] = (j == arg) ? amp : 0;
                1:       f[j] = amp;
                2:       f[j] = amp * (j - 64);
                default: f[j] = (j % 2 == 0) ? amp : -amp;
            endcase
        end
        return f;
    endfunction

    // Model of R4..R8: rotate, extend, weight, round, add, emit, move.
    task automatic model_frame(input frame_t f, input string tag);
        for (int i = 0; i < L; i++) begin
            longint p = longint'(f[(i + mrot) % K]) * longint'(win(i));
            mbuf[i] += int'((p + 65536) >>> 17);
        end
        for (int k = 0; k < M; k++) begin
            exp_q.push_back(clamp16(mbuf[k]));
            tag_q.push_back(tag);
        end
        for (int i = 0; i < L; i++) mbuf[i] = (i + M < L) ? mbuf[i + M] : 0;
        mrot = (mrot + M) % K;
    endtask

    task automatic do_reset();
        frame_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < L; i++) mbuf[i] = 0;
        mrot = 0;
        exp_q.delete();
        tag_q.delete();
    endtask

    // Drives one frame; junk with valid high while the block is not ready (R3).
    task automatic send_frame(input frame_t f, input string tag);
        for (int j = 0; j < K; j++) begin
            @(negedge clk);
            while (!frame_ready) begin
                frame_valid = 1'b1;
                frame_data  = 16'sh7FFF;
                @(negedge clk);
            end
            frame_valid = 1'b1;
            frame_data  = 16'(f[j]);
        end
        model_frame(f, tag);
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (M + 8) @(negedge clk);
        check("R2", exp_q.size(), 0);
    endtask

    // Output monitor: model comparison, burst length, ready exclusion.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            check("R2", int'(frame_ready), 0);
            if (bcnt < M) last_burst[bcnt] = int'(smp_data);
            bcnt++;
            if (exp_q.size() == 0) begin
                check("R2", 1, 0);
            end else begin
                string t = tag_q.pop_front();
                check(t, int'(smp_data), exp_q.pop_front());
            end
        end else if (bcnt != 0) begin
            check("R2", bcnt, M);
            check("R2", int'(frame_ready), 1);
            bcnt = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state at the ports.
        do_reset();
        check("R1", int'(frame_ready), 1);
        check("R1", int'(smp_valid), 0);

        // R5: impulse of 0.5 at sample 0 gives h[0]/2 = 400*... rounded 100.
        send_frame(make_frame(0, 16384, 0), "R5");
        drain();
        check("R5", last_burst[0], 100);
        check("R5", last_burst[1], 0);

        // R4: second frame rotated by 32, so sample 32 lands on position 0.
        send_frame(make_frame(0, 16384, 32), "R4");
        drain();
        check("R4", last_burst[0], 100);
        check("R4", last_burst[31], 0);

        // R1: reset clears earlier contributions.
        do_reset();
        send_frame(make_frame(1, 0, 0), "R1");
        drain();
        check("R1", last_burst[0], 0);

        // R6: exact half rounds up for both signs.
        do_reset();
        send_frame(make_frame(0, 2048, 0), "R6");
        drain();
        check("R6", last_burst[0], 13);
        do_reset();
        send_frame(make_frame(0, -2048, 0), "R6");
        drain();
        check("R6", last_burst[0], -12);

        // R3: frames back to back with junk held during each burst.
        do_reset();
        send_frame(make_frame(1, 1000, 0), "R3");
        send_frame(make_frame(2, 30, 0), "R3");
        send_frame(make_frame(0, -5000, 100), "R3");
        drain();

        // R7 and R8: table walk through all rotation phases and saturation.
        do_reset();
        for (int v = 0; v < NV; v++) begin
            string t = (VK[v] == 1 && (VA[v] >= 32767 || VA[v] <= -32768)) ? "R8" : "R7";
            send_frame(make_frame(VK[v], VA[v], VG[v]), t);
        end
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule